// File: doc/BRIEF.md
# Translation Unit Control and Fault Interrupt Block

This block is the register-controlled front end of an address translation unit. Software writes a 32-bit control register to switch translation on, to switch it off, or to request a blocked state. In the blocked state new traffic is stalled. A status bit confirms the block only once the outstanding-transaction count from the translation path has drained to zero. The block also holds the page table base and a configuration word, and it sends one-cycle flush strobes to the translation cache.

Fault events from the translation path carry a 3-bit fault kind and the offending virtual address. Each kind sets its own pending bit and loads the address register that belongs to its class. A fault taken while translation runs drives the unit into the blocked state on its own. The unit stays blocked until software writes the enable code again. Pending bits clear only through a write-one-to-clear register. The interrupt output is the OR of all pending bits.

The controller has four states. `ST_OFF` is disabled. `ST_RUN` translates. `ST_DRAIN` stalls while it waits for the count to reach zero. `ST_HELD` stalls with the blocked status set. The transitions are listed below.
- OFF to RUN on the enable code. OFF to DRAIN on the block code.
- RUN to DRAIN on the block code or on an accepted fault.
- DRAIN to HELD when the outstanding count is zero.
- DRAIN or HELD to RUN on the enable code, when no fault arrives in the same cycle.
- Any state to OFF on the disable code.

Top module: `xlat_ctl`

## Requirements
- R1: After reset the control register reads 0x0, the status and pending registers read 0, and `irq`, `stall` and `xlat_on` are all 0.
- R2: The control register (offset 0x00) takes only three codes. 0x5 enables translation: `xlat_on`=1, `stall`=0, and it reads back 0x5. 0x0 disables the unit: `xlat_on`=0. Any other value is ignored and leaves the state unchanged.
- R3: Code 0x7 (block) asserts `stall` from the next cycle and reads back 0x7. Status bit 0 (offset 0x08) becomes 1 only in the cycle after `txn_cnt` has been sampled at zero.
- R4: Writing 0x5 while blocked or draining releases `stall`, clears status bit 0 and keeps `xlat_on` at 1.
- R5: A fault with kind k (0 to 7), taken while the unit is not disabled, sets bit k of the pending register (offset 0x18), and `irq` is the OR of the pending bits. Faults while disabled are ignored.
- R6: A fault taken in the running state makes `stall` rise in the next cycle, and the control register then reads 0x7.
- R7: The fault address is captured by class. Kind 0 (missing page) goes to 0x24. Kinds 2, 6 and 7 (write faults) go to 0x28. Kinds 1, 4 and 5 (read faults) go to 0x2C. Kind 3 (bus error) goes to 0x30.
- R8: Writing to offset 0x1C clears each pending bit whose write-data bit is 1 and leaves the others unchanged.
- R9: A write to the page table base (offset 0x14) stores the value and pulses `flush_all` for one cycle. A write to offset 0x0C with bit 0 set pulses `flush_all`, and with bit 0 clear it has no effect.
- R10: A write to offset 0x10 with bit 0 set pulses `flush_entry` for one cycle. `flush_va` carries the write data with its low 12 bits cleared. With bit 0 clear, nothing is pulsed.
- R11: Offset 0x34 reads the 11-bit version in bits [31:21]: the major number in bits [10:7] of that field and the minor number in bits [6:0].
- R12: The configuration register (offset 0x04) reads back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| flt_valid | input | 1 | Fault event strobe |
| flt_kind | input | 3 | Fault kind index |
| flt_va | input | 32 | Faulting virtual address |
| txn_cnt | input | 6 | Outstanding transactions in the translation path |
| stall | output | 1 | Hold off new transactions |
| xlat_on | output | 1 | Translation enabled |
| flush_all | output | 1 | Full translation-cache flush pulse |
| flush_entry | output | 1 | Single-entry flush pulse |
| flush_va | output | 32 | Page address for the entry flush |
| irq | output | 1 | Fault interrupt |

## Verification
A controller stuck in the wrong state shows up one cycle after the control write or fault that should have moved it. It appears as a wrong `stall` or `xlat_on` level, or as a control readback other than 0x0, 0x5 or 0x7. A drain that completes early sets status bit 0 while `txn_cnt` is still nonzero, and this is visible within the cycle after the count is sampled. Pending bits or address capture sent to the wrong place appear at once in the pending register or the class address registers. The bench sweeps every fault kind, every control code from 0 to 15, and single-bit and complementary clear masks.

// File: rtl/xlat_ctl_pkg.sv
package xlat_ctl_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_HELD  = 2'd3
    } ctl_state_t;

    localparam logic [31:0] CODE_OFF = 32'h0;
    localparam logic [31:0] CODE_EN  = 32'h5;
    localparam logic [31:0] CODE_BLK = 32'h7;

    localparam logic [7:0] OFS_CTL    = 8'h00;
    localparam logic [7:0] OFS_CFG    = 8'h04;
    localparam logic [7:0] OFS_STAT   = 8'h08;
    localparam logic [7:0] OFS_FLALL  = 8'h0C;
    localparam logic [7:0] OFS_FLENT  = 8'h10;
    localparam logic [7:0] OFS_PTB    = 8'h14;
    localparam logic [7:0] OFS_PEND   = 8'h18;
    localparam logic [7:0] OFS_CLR    = 8'h1C;
    localparam logic [7:0] OFS_A_PAGE = 8'h24;
    localparam logic [7:0] OFS_A_WR   = 8'h28;
    localparam logic [7:0] OFS_A_RD   = 8'h2C;
    localparam logic [7:0] OFS_A_BUS  = 8'h30;
    localparam logic [7:0] OFS_VER    = 8'h34;

    // address class: 0 page, 1 write, 2 read, 3 bus error
    function automatic logic [1:0] fault_class(input logic [2:0] kind);
        unique case (kind)
            3'd0:                 return 2'd0;
            3'd1, 3'd4, 3'd5:     return 2'd2;
            3'd3:                 return 2'd3;
            default:              return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/xlat_ctl_fsm.sv
module xlat_ctl_fsm
    import xlat_ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_code,
    input  logic        flt_hit,
    input  logic        txn_idle,
    output logic        on,
    output logic        stall,
    output logic        blocked,
    output logic [31:0] ctl_rb
);
    ctl_state_t st, st_nx;

    wire go_off = cmd_wr && (cmd_code == CODE_OFF);
    wire go_en  = cmd_wr && (cmd_code == CODE_EN);
    wire go_blk = cmd_wr && (cmd_code == CODE_BLK);

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_OFF: begin
                if (go_en)       st_nx = ST_RUN;
                else if (go_blk) st_nx = ST_DRAIN;
            end
            ST_RUN: begin
                if (go_off)                 st_nx = ST_OFF;
                else if (flt_hit || go_blk) st_nx = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (go_off)                 st_nx = ST_OFF;
                else if (go_en && !flt_hit) st_nx = ST_RUN;
                else if (txn_idle)          st_nx = ST_HELD;
            end
            ST_HELD: begin
                if (go_off)                 st_nx = ST_OFF;
                else if (go_en && !flt_hit) st_nx = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= st_nx;
    end

    always_comb begin
        on      = 1'b0;
        stall   = 1'b0;
        blocked = 1'b0;
        ctl_rb  = CODE_OFF;
        unique case (st)
            ST_OFF:   ;
            ST_RUN:   begin on = 1'b1; ctl_rb = CODE_EN; end
            ST_DRAIN: begin on = 1'b1; stall = 1'b1; ctl_rb = CODE_BLK; end
            ST_HELD:  begin on = 1'b1; stall = 1'b1; blocked = 1'b1; ctl_rb = CODE_BLK; end
        endcase
    end
endmodule

// File: rtl/xlat_ctl_faults.sv
module xlat_ctl_faults
    import xlat_ctl_pkg::*;
#(
    parameter int NKIND = 8,
    parameter int VA_W  = 32,
    localparam int KW   = $clog2(NKIND),
    localparam int NCLS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic [KW-1:0]        kind,
    input  logic [VA_W-1:0]      va,
    input  logic                 clr_wr,
    input  logic [NKIND-1:0]     clr_mask,
    output logic [NKIND-1:0]     pend,
    output logic [VA_W-1:0]      cls_va [NCLS]
);
    logic [1:0] cls;
    assign cls = fault_class(kind);

    for (genvar i = 0; i < NKIND; i++) begin : g_pend
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[i] <= 1'b0;
            else if (accept && kind == KW'(i))
                pend[i] <= 1'b1;
            else if (clr_wr && clr_mask[i])
                pend[i] <= 1'b0;
        end
    end

    for (genvar c = 0; c < NCLS; c++) begin : g_va
        always_ff @(posedge clk) begin
            if (!rst_n)
                cls_va[c] <= '0;
            else if (accept && cls == 2'(c))
                cls_va[c] <= va;
        end
    end
endmodule

// File: rtl/xlat_ctl.sv
module xlat_ctl
    import xlat_ctl_pkg::*;
#(
    parameter int CNT_W    = 6,
    parameter int PG_SHIFT = 12,
    parameter int VER_MAJ  = 3,
    parameter int VER_MIN  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [7:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             flt_valid,
    input  logic [2:0]       flt_kind,
    input  logic [31:0]      flt_va,
    input  logic [CNT_W-1:0] txn_cnt,
    output logic             stall,
    output logic             xlat_on,
    output logic             flush_all,
    output logic             flush_entry,
    output logic [31:0]      flush_va,
    output logic             irq
);
    localparam int NKIND = 8;
    localparam logic [31:0] VER_WORD =
        {4'(VER_MAJ), 7'(VER_MIN), 21'd0};

    logic        st_blocked;
    logic [31:0] ctl_rb;
    logic [31:0] cfg_q, ptb_q;
    logic [NKIND-1:0] pend;
    logic [31:0] cls_va [4];

    wire wr_ctl = reg_wr && reg_addr == OFS_CTL;
    wire flt_hit = flt_valid && xlat_on;

    xlat_ctl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (wr_ctl),
        .cmd_code (reg_wdata),
        .flt_hit  (flt_hit),
        .txn_idle (txn_cnt == '0),
        .on       (xlat_on),
        .stall    (stall),
        .blocked  (st_blocked),
        .ctl_rb   (ctl_rb)
    );

    xlat_ctl_faults #(.NKIND(NKIND), .VA_W(32)) u_flt (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (flt_hit),
        .kind     (flt_kind),
        .va       (flt_va),
        .clr_wr   (reg_wr && reg_addr == OFS_CLR),
        .clr_mask (reg_wdata[NKIND-1:0]),
        .pend     (pend),
        .cls_va   (cls_va)
    );

    assign irq = |pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q       <= '0;
            ptb_q       <= '0;
            flush_all   <= 1'b0;
            flush_entry <= 1'b0;
            flush_va    <= '0;
        end else begin
            flush_all   <= reg_wr && (reg_addr == OFS_PTB ||
                           (reg_addr == OFS_FLALL && reg_wdata[0]));
            flush_entry <= reg_wr && reg_addr == OFS_FLENT && reg_wdata[0];
            if (reg_wr && reg_addr == OFS_CFG) cfg_q <= reg_wdata;
            if (reg_wr && reg_addr == OFS_PTB) ptb_q <= reg_wdata;
            if (reg_wr && reg_addr == OFS_FLENT)
                flush_va <= {reg_wdata[31:PG_SHIFT], {PG_SHIFT{1'b0}}};
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_CTL:    reg_rdata = ctl_rb;
            OFS_CFG:    reg_rdata = cfg_q;
            OFS_STAT:   reg_rdata = {31'd0, st_blocked};
            OFS_PTB:    reg_rdata = ptb_q;
            OFS_PEND:   reg_rdata = {{(32-NKIND){1'b0}}, pend};
            OFS_A_PAGE: reg_rdata = cls_va[0];
            OFS_A_WR:   reg_rdata = cls_va[1];
            OFS_A_RD:   reg_rdata = cls_va[2];
            OFS_A_BUS:  reg_rdata = cls_va[3];
            OFS_VER:    reg_rdata = VER_WORD;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/xlat_ctl_sva.sv
module xlat_ctl_sva #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [7:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             flt_valid,
    input logic [CNT_W-1:0] txn_cnt,
    input logic             stall,
    input logic             xlat_on,
    input logic             irq,
    input logic             flush_all,
    input logic             st_blocked
);
    AST_OFF_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !xlat_on |-> !stall); // R2

    AST_BLOCK_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_blocked) |-> $past(txn_cnt) == '0); // R3

    AST_ENABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'h00 && reg_wdata == 32'h5 && !flt_valid)
        |=> (xlat_on && !stall && !st_blocked)); // R4

    AST_FAULT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && xlat_on) |=> irq); // R5

    AST_FAULT_AUTO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && xlat_on && !(reg_wr && reg_addr == 8'h00)) |=> stall); // R6

    AST_PTB_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'h14) |=> flush_all); // R9
endmodule

bind xlat_ctl xlat_ctl_sva #(.CNT_W(CNT_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .flt_valid  (flt_valid),
    .txn_cnt    (txn_cnt),
    .stall      (stall),
    .xlat_on    (xlat_on),
    .irq        (irq),
    .flush_all  (flush_all),
    .st_blocked (st_blocked)
);

// File: tb/tb_xlat_ctl.sv
module tb_xlat_ctl;
    localparam int VMAJ = 3;
    localparam int VMIN = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        flt_valid = 1'b0;
    logic [2:0]  flt_kind = '0;
    logic [31:0] flt_va = '0;
    logic [5:0]  txn_cnt = '0;
    logic        stall, xlat_on, flush_all, flush_entry, irq;
    logic [31:0] flush_va;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    xlat_ctl #(.CNT_W(6), .PG_SHIFT(12), .VER_MAJ(VMAJ), .VER_MIN(VMIN)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flt_valid(flt_valid),
        .flt_kind(flt_kind), .flt_va(flt_va), .txn_cnt(txn_cnt), .stall(stall),
        .xlat_on(xlat_on), .flush_all(flush_all), .flush_entry(flush_entry),
        .flush_va(flush_va), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic fault(input logic [2:0] k, input logic [31:0] va);
        @(negedge clk);
        flt_valid = 1'b1; flt_kind = k; flt_va = va;
        @(negedge clk);
        flt_valid = 1'b0;
        #1;
    endtask

    function automatic logic [7:0] addr_of(input int k);
        if (k == 0) return 8'h24;
        if (k == 3) return 8'h30;
        if (k == 1 || k == 4 || k == 5) return 8'h2C;
        return 8'h28;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        rd(8'h00, v); chk("R1 ctl", v, 32'h0);
        rd(8'h08, v); chk("R1 status", v, 32'h0);
        rd(8'h18, v); chk("R1 pend", v, 32'h0);
        chk("R1 outs", {29'd0, irq, stall, xlat_on}, 32'h0);

        // R12 config
        wr(8'h04, 32'hA5A5_1234);
        rd(8'h04, v); chk("R12 cfg", v, 32'hA5A5_1234);

        // R11 version
        rd(8'h34, v); chk("R11 version", v, ((VMAJ << 7) | VMIN) << 21);

        // R5 faults ignored when off
        fault(3'd0, 32'hDEAD_0000);
        chk("R5 off irq", {31'd0, irq}, 32'h0);
        rd(8'h18, v); chk("R5 off pend", v, 32'h0);

        // R2 control code sweep from off
        for (int c = 0; c < 16; c++) begin
            wr(8'h00, c);
            rd(8'h00, v);
            chk("R2 readback", v, (c == 5 || c == 7) ? c : 0);
            chk("R2 on", {31'd0, xlat_on}, (c == 5 || c == 7) ? 1 : 0);
            chk("R3 stall", {31'd0, stall}, (c == 7) ? 1 : 0);
            wr(8'h00, 32'h0);
            chk("R2 off", {30'd0, xlat_on, stall}, 32'h0);
        end

        // R2 ignored codes while running
        wr(8'h00, 32'h5);
        wr(8'h00, 32'h6);
        rd(8'h00, v); chk("R2 ignore in run", v, 32'h5);

        // R3 drain
        txn_cnt = 6'd3;
        wr(8'h00, 32'h7);
        chk("R3 stall", {31'd0, stall}, 32'h1);
        rd(8'h08, v); chk("R3 not yet blocked", v, 32'h0);
        repeat (3) @(negedge clk);
        #1;
        rd(8'h08, v); chk("R3 still draining", v, 32'h0);
        txn_cnt = 6'd0;
        @(negedge clk); #1;
        rd(8'h08, v); chk("R3 blocked", v, 32'h1);
        rd(8'h00, v); chk("R3 ctl", v, 32'h7);

        // R4 enable releases
        wr(8'h00, 32'h5);
        chk("R4 stall", {31'd0, stall}, 32'h0);
        chk("R4 on", {31'd0, xlat_on}, 32'h1);
        rd(8'h08, v); chk("R4 status", v, 32'h0);

        // R5 R6 R7 R8 fault sweep
        for (int k = 0; k < 8; k++) begin
            logic [31:0] va;
            va = 32'h1000_0000 * (k + 1) + 32'h100 * k + k;
            fault(k[2:0], va);
            chk("R6 auto stall", {31'd0, stall}, 32'h1);
            rd(8'h00, v); chk("R6 ctl", v, 32'h7);
            chk("R5 irq", {31'd0, irq}, 32'h1);
            rd(8'h18, v); chk("R5 pend", v, 32'h1 << k);
            rd(addr_of(k), v); chk("R7 addr", v, va);
            wr(8'h00, 32'h5);
            chk("R4 resume", {31'd0, stall}, 32'h0);
            wr(8'h1C, ~(32'h1 << k) & 32'hFF);
            rd(8'h18, v); chk("R8 other bits", v, 32'h1 << k);
            wr(8'h1C, 32'h1 << k);
            rd(8'h18, v); chk("R8 cleared", v, 32'h0);
            chk("R8 irq low", {31'd0, irq}, 32'h0);
        end

        // R5 R7 two pending while blocked
        fault(3'd2, 32'h0000_2222);
        fault(3'd6, 32'h0000_6666);
        rd(8'h18, v); chk("R5 two pending", v, 32'h44);
        rd(8'h28, v); chk("R7 last write fault", v, 32'h0000_6666);
        wr(8'h1C, 32'hFF);
        rd(8'h18, v); chk("R8 clear all", v, 32'h0);
        wr(8'h00, 32'h5);

        // R9 flush all
        wr(8'h14, 32'h8000_4000);
        chk("R9 ptb flush", {31'd0, flush_all}, 32'h1);
        rd(8'h14, v); chk("R9 ptb", v, 32'h8000_4000);
        @(negedge clk); #1;
        chk("R9 one cycle", {31'd0, flush_all}, 32'h0);
        wr(8'h0C, 32'h1);
        chk("R9 flush reg", {31'd0, flush_all}, 32'h1);
        wr(8'h0C, 32'h0);
        chk("R9 flush bit0 clear", {31'd0, flush_all}, 32'h0);

        // R10 entry flush
        wr(8'h10, 32'h1234_5679);
        chk("R10 pulse", {31'd0, flush_entry}, 32'h1);
        chk("R10 va", flush_va, 32'h1234_5000);
        wr(8'h10, 32'h1234_5678);
        chk("R10 no pulse", {31'd0, flush_entry}, 32'h0);

        // R2 disable
        wr(8'h00, 32'h0);
        chk("R2 disabled", {31'd0, xlat_on}, 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule